// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between the free-running source clocks of a multi-output clock generator and its output pins. A single shared pin first acts as an active-low power-good input and, once it has been seen low, becomes an active-high power-down request. When power-down is accepted, every output stops cleanly on an edge of its own clock. Single-ended outputs are held low. Each differential pair is parked in a state chosen by its group's float bit. When the request is withdrawn, the outputs restart once the PLL reports lock.

Each output is gated by its own flop, clocked by that output's source clock. The flop is fed by a two-stage synchronizer from the control domain. The control domain runs on the CPU complement clock. Per-output enable bits park an output on their own. A drive-mode bit for each of the three differential groups (CPU, SRC, DOT) picks the parked state for that group. Output-enable flags stand in for tri-state pads. A flag stands in for the doubled drive current.

Top module: `clkout_pwrdn_seq`

## Requirements
- R1: After reset all outputs are parked and `pwr_pin` is read as active-low power-good. Outputs may start only after `pwr_pin` has been sampled low. After that, `pwr_pin` high is a power-down request.
- R2: Power-down is accepted only when `pwr_pin` is sampled high on two consecutive `ctl_clk` rising edges. If the pin goes high before edge k and stays high, acceptance takes effect at edge k+3. A pin high for a single edge is ignored.
- R3: A single-ended output (`se_out`) is forced low starting at a falling edge of its own source. It is low within 4 of its own periods after acceptance. Every high pulse it produces lasts exactly half its source period, so no runt pulse is produced.
- R4: A differential pair stops on a falling edge of its complement, which is a rising edge of `dif_src`. It is parked within 4 of its own periods after acceptance.
- R5: With the group float bit at 0, a parked enabled pair has `dif_t`=1, `dif_t_oe`=1, `dif_t_hi`=1 and `dif_c_oe`=0.
- R6: With the group float bit at 1, a parked pair has `dif_t_oe`=0, `dif_c_oe`=0 and `dif_t_hi`=0.
- R7: Float bits are per group. `float_cpu` covers pair indices 0..N_CPU-1. `float_src` covers the next N_SRC pairs. `float_dot` covers the rest.
- R8: After power-down is released, outputs stay parked until `pll_locked` has been sampled high on `ctl_clk`.
- R9: Once power-good, no request and lock all hold, every enabled output runs within 3 `ctl_clk` periods plus 4 of its own periods. A running pair has both output enables at 1, `dif_t_hi`=0 and `dif_c` = ~`dif_t`.
- R10: An enable bit of 0 parks its output with the same edge-aligned rule. A disabled single-ended output is low. A disabled pair has both output enables at 0, whatever the float bit. A disabled output stays parked across power-down cycles, and setting the bit back to 1 restarts it.
- R11: `stop_busy` rises at acceptance while any output still runs. It falls once all outputs are parked, and it stays low when no power-down is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock: the CPU complement source clock |
| rst_n | input | 1 | Synchronous active-low reset, held across several periods of every source |
| pwr_pin | input | 1 | Shared power-good (active low) then power-down (active high) pin, asynchronous |
| pll_locked | input | 1 | PLL lock flag, asynchronous |
| se_src | input | N_SE | Free-running single-ended source clocks |
| dif_src | input | N_CPU+N_SRC+N_DOT | Free-running true-phase source clocks of the differential pairs |
| se_en | input | N_SE | Per-output enable of single-ended outputs |
| dif_en | input | N_CPU+N_SRC+N_DOT | Per-pair enable of differential outputs |
| float_cpu | input | 1 | Parked state of CPU pairs: 0 true-high drive, 1 both floating |
| float_src | input | 1 | Parked state of SRC pairs |
| float_dot | input | 1 | Parked state of DOT pairs |
| se_out | output | N_SE | Gated single-ended clocks |
| dif_t | output | N_CPU+N_SRC+N_DOT | True line level of each pair |
| dif_c | output | N_CPU+N_SRC+N_DOT | Complement line level of each pair |
| dif_t_oe | output | N_CPU+N_SRC+N_DOT | True line output enable (0 = tri-state) |
| dif_c_oe | output | N_CPU+N_SRC+N_DOT | Complement line output enable (0 = tri-state) |
| dif_t_hi | output | N_CPU+N_SRC+N_DOT | True line driven at doubled current |
| stop_busy | output | 1 | High while power-down is accepted and some output still runs |

## Verification
Acceptance is due exactly at the fourth `ctl_clk` rising edge that samples the pin high. The bench samples 1 ns after the third edge, expecting no acceptance, and 1 ns after the fourth, expecting it. Each output's parked state is due within 4 of its own periods of acceptance, so the bench checks each output at that output's bound, counted from the acceptance edge. Restart is due within 3 control periods plus 4 own periods. The bench waits out that bound and then counts edges over a window of several periods, and it checks pulse widths on every single-ended pulse.

// File: rtl/clkpd_pkg.sv
`timescale 1ns/1ps
// Shared types and constants of the clock output power-down sequencer.
// Assumes: group indices are laid out CPU first, then SRC, then DOT.
package clkpd_pkg;

    // Differential output groups, each with its own parked-state mode bit.
    typedef enum logic [1:0] {
        GRP_CPU = 2'd0,
        GRP_SRC = 2'd1,
        GRP_DOT = 2'd2
    } dif_grp_e;

    // Stages of the per-output synchronizer into the output's clock domain.
    localparam int SYNC_DEPTH = 2;

    // Late-stop checker: counter width and the largest allowed count of
    // source periods between a stop request and the gate closing.
    localparam int LATE_W     = 3;
    localparam int LATE_LIMIT = 3;

    // Maps a pair index to its group from the group sizes.
    function automatic dif_grp_e grp_of(input int idx, input int n_cpu, input int n_src);
        if (idx < n_cpu)
            return GRP_CPU;
        else if (idx < n_cpu + n_src)
            return GRP_SRC;
        else
            return GRP_DOT;
    endfunction

endpackage

// File: rtl/pd_pin_ctrl.sv
`timescale 1ns/1ps
// Control-domain interpreter of the shared power-good / power-down pin.
// Runs on the CPU complement clock. The pin and the lock flag are
// asynchronous and are synchronized here. Produces run_req, the common
// permission for outputs to run, and pd_acc, the accepted power-down.
// Assumes: rst_n is held for at least one ctl clock edge.
module pd_pin_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pll_locked,
    output logic run_req,
    output logic pd_acc
);

    logic [2:0] pin_q;    // [0] first sync stage, [1] and [2] consecutive clean samples
    logic [1:0] lock_q;
    logic       armed_q;  // pin has been seen low: power-good reached
    logic       pd_q;

    // Shift the pin through a synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 3'b111;
        else
            pin_q <= {pin_q[1:0], pin};
    end

    // Synchronize the PLL lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 2'b00;
        else
            lock_q <= {lock_q[0], pll_locked};
    end

    // Leave the power-good phase once the pin has been sampled low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (!pin_q[1])
            armed_q <= 1'b1;
    end

    // Accept or release power-down on two matching consecutive samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed_q)
            pd_q <= 1'b0;
        else if (pin_q[1] && pin_q[2])
            pd_q <= 1'b1;
        else if (!pin_q[1] && !pin_q[2])
            pd_q <= 1'b0;
    end

    assign run_req = armed_q & ~pd_q & lock_q[1];
    assign pd_acc  = pd_q;

    // R1: leaving power-good phase implies the pin was low.
    assert_pg_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> !$past(pin, 3));

    // R2: acceptance implies two consecutive high samples of the raw pin.
    assert_accept_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_q) |-> ($past(pin, 3) && $past(pin, 4)));

    // R8: permission to run implies the lock flag was high.
    assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_req |-> $past(pll_locked, 2));

endmodule

// File: rtl/se_gate.sv
`timescale 1ns/1ps
// Glitch-free gate for one single-ended clock output.
// The run request crosses into the source domain through a synchronizer
// on rising edges. The gate flop changes only on falling edges, while the
// source is low, so every high pulse that leaves is complete.
// Assumes: the source clock runs during reset.
module se_gate
    import clkpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    output logic out,
    output logic gate
);

    logic [SYNC_DEPTH-1:0] want_q;
    logic                  gate_q;
    logic [LATE_W-1:0]     late_cnt;

    // Bring the request into this output's domain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            want_q <= '0;
        else
            want_q <= {want_q[SYNC_DEPTH-2:0], want};
    end

    // Open or close the gate while the source is low.
    always_ff @(negedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= want_q[SYNC_DEPTH-1];
    end

    assign out  = clk & gate_q;
    assign gate = gate_q;

    // Checker: count falling edges between the request drop and the gate closing.
    always_ff @(negedge clk) begin
        if (!rst_n)
            late_cnt <= '0;
        else if (!want && gate_q)
            late_cnt <= (late_cnt == '1) ? late_cnt : late_cnt + 1'b1;
        else
            late_cnt <= '0;
    end

    // R3: the output is low within the stop bound of its own periods.
    assert_se_bound_R3: assert property (@(negedge clk) disable iff (!rst_n)
        late_cnt <= LATE_W'(LATE_LIMIT));

endmodule

// File: rtl/dif_gate.sv
`timescale 1ns/1ps
// Glitch-free gate for one differential pair.
// The complement is the inverse of the true source, so the complement's
// high-to-low transition is the true source's rising edge. The gate
// changes there. The synchronizer runs on the opposite edge.
// The parked state follows the group float bit, or is fully floating when
// the pair is disabled.
// Assumes: float and enable bits are quasi-static with respect to the source.
module dif_gate
    import clkpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic en,
    input  logic float_park,
    output logic t,
    output logic c,
    output logic t_oe,
    output logic c_oe,
    output logic t_hi,
    output logic gate
);

    logic [SYNC_DEPTH-1:0] want_q;
    logic                  gate_q;
    logic [LATE_W-1:0]     late_cnt;

    // Bring the request into this pair's domain on complement rising edges.
    always_ff @(negedge clk) begin
        if (!rst_n)
            want_q <= '0;
        else
            want_q <= {want_q[SYNC_DEPTH-2:0], want};
    end

    // Open or close the gate on complement falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= want_q[SYNC_DEPTH-1];
    end

    // Pin levels and enables: running, parked with true high, or floating.
    always_comb begin
        if (gate_q) begin
            t    = clk;
            c    = ~clk;
            t_oe = 1'b1;
            c_oe = 1'b1;
            t_hi = 1'b0;
        end else if (en && !float_park) begin
            t    = 1'b1;
            c    = 1'b0;
            t_oe = 1'b1;
            c_oe = 1'b0;
            t_hi = 1'b1;
        end else begin
            t    = 1'b0;
            c    = 1'b0;
            t_oe = 1'b0;
            c_oe = 1'b0;
            t_hi = 1'b0;
        end
    end

    assign gate = gate_q;

    // Checker: count true rising edges between the request drop and the gate closing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            late_cnt <= '0;
        else if (!want && gate_q)
            late_cnt <= (late_cnt == '1) ? late_cnt : late_cnt + 1'b1;
        else
            late_cnt <= '0;
    end

    // R4: the pair parks within the stop bound of its own periods.
    assert_dif_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        late_cnt <= LATE_W'(LATE_LIMIT));

    // R5: a parked pair in drive mode keeps the true line high at double current.
    assert_park_drive_R5: assert property (@(negedge clk) disable iff (!rst_n)
        (!gate_q && en && !float_park) |-> (t && t_oe && t_hi && !c_oe));

    // R6: a parked pair in float mode releases both lines.
    assert_park_float_R6: assert property (@(negedge clk) disable iff (!rst_n)
        (!gate_q && float_park) |-> (!t_oe && !c_oe && !t_hi));

endmodule

// File: rtl/clkout_pwrdn_seq.sv
`timescale 1ns/1ps
// Top of the clock output power-down sequencer.
// One control block interprets the shared pin and the lock flag. One gate
// per output stops and restarts that output on its own clock edges.
// Assumes: ctl_clk is the complement of the CPU source clock, and rst_n is
// held across several periods of every source clock.
module clkout_pwrdn_seq
    import clkpd_pkg::*;
#(
    parameter int N_SE  = 3,
    parameter int N_CPU = 2,
    parameter int N_SRC = 2,
    parameter int N_DOT = 1
) (
    input  logic                         ctl_clk,
    input  logic                         rst_n,
    input  logic                         pwr_pin,
    input  logic                         pll_locked,
    input  logic [N_SE-1:0]              se_src,
    input  logic [N_CPU+N_SRC+N_DOT-1:0] dif_src,
    input  logic [N_SE-1:0]              se_en,
    input  logic [N_CPU+N_SRC+N_DOT-1:0] dif_en,
    input  logic                         float_cpu,
    input  logic                         float_src,
    input  logic                         float_dot,
    output logic [N_SE-1:0]              se_out,
    output logic [N_CPU+N_SRC+N_DOT-1:0] dif_t,
    output logic [N_CPU+N_SRC+N_DOT-1:0] dif_c,
    output logic [N_CPU+N_SRC+N_DOT-1:0] dif_t_oe,
    output logic [N_CPU+N_SRC+N_DOT-1:0] dif_c_oe,
    output logic [N_CPU+N_SRC+N_DOT-1:0] dif_t_hi,
    output logic                         stop_busy
);

    localparam int N_DIFF = N_CPU + N_SRC + N_DOT;

    logic              run_req;
    logic              pd_acc;
    logic [N_SE-1:0]   se_gate_on;
    logic [N_DIFF-1:0] dif_gate_on;

    pd_pin_ctrl u_ctrl (
        .clk        (ctl_clk),
        .rst_n      (rst_n),
        .pin        (pwr_pin),
        .pll_locked (pll_locked),
        .run_req    (run_req),
        .pd_acc     (pd_acc)
    );

    // One gate per single-ended output.
    for (genvar i = 0; i < N_SE; i++) begin : g_se
        se_gate u_gate (
            .clk   (se_src[i]),
            .rst_n (rst_n),
            .want  (run_req & se_en[i]),
            .out   (se_out[i]),
            .gate  (se_gate_on[i])
        );
    end

    // One gate per differential pair. The float bit is picked by group (R7).
    for (genvar j = 0; j < N_DIFF; j++) begin : g_dif
        localparam dif_grp_e GRP = grp_of(j, N_CPU, N_SRC);
        logic fl;
        if (GRP == GRP_CPU) begin : g_cpu
            assign fl = float_cpu;
        end else if (GRP == GRP_SRC) begin : g_src
            assign fl = float_src;
        end else begin : g_dot
            assign fl = float_dot;
        end

        dif_gate u_gate (
            .clk        (dif_src[j]),
            .rst_n      (rst_n),
            .want       (run_req & dif_en[j]),
            .en         (dif_en[j]),
            .float_park (fl),
            .t          (dif_t[j]),
            .c          (dif_c[j]),
            .t_oe       (dif_t_oe[j]),
            .c_oe       (dif_c_oe[j]),
            .t_hi       (dif_t_hi[j]),
            .gate       (dif_gate_on[j])
        );
    end

    // Status: power-down accepted and some gate still open (R11).
    assign stop_busy = pd_acc & ((|se_gate_on) | (|dif_gate_on));

endmodule

// File: tb/clkout_pwrdn_seq_test.sv
`timescale 1ns/1ps
// Self-checking bench for the clock output power-down sequencer.
module clkout_pwrdn_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_SE   = 3;
    localparam int N_CPU  = 2;
    localparam int N_SRC  = 2;
    localparam int N_DOT  = 1;
    localparam int N_DIFF = N_CPU + N_SRC + N_DOT;
    localparam int SE_PER  [N_SE]   = '{30, 20, 42};
    localparam int DIF_PER [N_DIFF] = '{CLK_PERIOD, CLK_PERIOD, 12, 12, 14};
    localparam int WATCHDOG = 200000;

    logic ctl_clk, rst_n, pwr_pin, pll_locked;
    logic [N_SE-1:0]   se_src, se_en, se_out;
    logic [N_DIFF-1:0] dif_src, dif_en, dif_t, dif_c, dif_t_oe, dif_c_oe, dif_t_hi;
    logic float_cpu, float_src, float_dot, stop_busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    bit busy_seen;
    int se_edges  [N_SE];
    int dif_edges [N_DIFF];

    clkout_pwrdn_seq #(.N_SE(N_SE), .N_CPU(N_CPU), .N_SRC(N_SRC), .N_DOT(N_DOT)) uut (
        .ctl_clk(ctl_clk), .rst_n(rst_n), .pwr_pin(pwr_pin), .pll_locked(pll_locked),
        .se_src(se_src), .dif_src(dif_src), .se_en(se_en), .dif_en(dif_en),
        .float_cpu(float_cpu), .float_src(float_src), .float_dot(float_dot),
        .se_out(se_out), .dif_t(dif_t), .dif_c(dif_c), .dif_t_oe(dif_t_oe),
        .dif_c_oe(dif_c_oe), .dif_t_hi(dif_t_hi), .stop_busy(stop_busy)
    );

    // Source clocks; the control clock is the CPU complement.
    for (genvar g = 0; g < N_SE; g++) begin : g_se_clk
        initial begin
            se_src[g] = 1'b0;
            forever #(SE_PER[g] / 2) se_src[g] = ~se_src[g];
        end
        int rise_t = -1;
        always @(posedge se_out[g]) begin
            se_edges[g] = se_edges[g] + 1;
            rise_t = rst_n ? int'($time) : -1;
        end
        // R3: every high pulse lasts exactly half the source period.
        always @(negedge se_out[g]) begin
            if (rise_t >= 0 && rst_n)
                check((int'($time) - rise_t) == SE_PER[g] / 2, "R3", "pulse width",
                      int'($time) - rise_t, SE_PER[g] / 2);
            rise_t = -1;
        end
    end
    for (genvar g = 0; g < N_DIFF; g++) begin : g_dif_clk
        initial begin
            dif_src[g] = 1'b0;
            #1;
            forever #(DIF_PER[g] / 2) dif_src[g] = ~dif_src[g];
        end
        always @(posedge dif_t[g]) dif_edges[g] = dif_edges[g] + 1;
    end
    assign ctl_clk = ~dif_src[0];

    always @(posedge stop_busy) busy_seen = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < N_SE; i++) se_edges[i] = 0;
        for (int j = 0; j < N_DIFF; j++) dif_edges[j] = 0;
    endtask

    // R7: group of pair j selects its float bit.
    function automatic bit float_of(input int j);
        if (j < N_CPU) return float_cpu;
        if (j < N_CPU + N_SRC) return float_src;
        return float_dot;
    endfunction

    task automatic check_pair_parked(input int j, input string req);
        if (float_of(j)) begin
            check(!dif_t_oe[j] && !dif_c_oe[j] && !dif_t_hi[j], req, $sformatf("pair %0d float oe_t,oe_c,hi", j),
                  {dif_t_oe[j], dif_c_oe[j], dif_t_hi[j]}, 0);
        end else begin
            check(dif_t[j] && dif_t_oe[j] && dif_t_hi[j] && !dif_c_oe[j], req,
                  $sformatf("pair %0d drive t,oe_t,hi,oe_c", j),
                  {dif_t[j], dif_t_oe[j], dif_t_hi[j], dif_c_oe[j]}, 4'b1110);
        end
    endtask

    // Counts edges over a window and checks every output stayed parked.
    task automatic check_all_parked(input string req);
        clear_counts();
        #150;
        for (int i = 0; i < N_SE; i++)
            check(se_edges[i] == 0 && se_out[i] == 1'b0, req, $sformatf("se %0d edges", i), se_edges[i], 0);
        for (int j = 0; j < N_DIFF; j++) begin
            check(dif_edges[j] == 0, req, $sformatf("pair %0d edges", j), dif_edges[j], 0);
            check_pair_parked(j, req);
        end
    endtask

    // Counts edges over a window and checks each output selected in the masks runs.
    task automatic check_running(input string req, input logic [N_SE-1:0] se_m,
                                 input logic [N_DIFF-1:0] dif_m);
        clear_counts();
        #200;
        for (int i = 0; i < N_SE; i++)
            if (se_m[i]) check(se_edges[i] > 0, req, $sformatf("se %0d edges", i), se_edges[i], 1);
        for (int j = 0; j < N_DIFF; j++)
            if (dif_m[j]) begin
                check(dif_edges[j] > 0 && dif_t_oe[j] && dif_c_oe[j] && !dif_t_hi[j]
                      && (dif_c[j] == ~dif_t[j]), req, $sformatf("pair %0d running", j),
                      dif_edges[j], 1);
            end
    endtask

    task automatic power_down_staggered();
        // R2: pin high before edge k; no acceptance after k+2, acceptance after k+3.
        @(negedge ctl_clk) pwr_pin = 1'b1;
        repeat (3) @(posedge ctl_clk);
        #1 check(stop_busy == 1'b0, "R2", "busy before third sample", stop_busy, 0);
        @(posedge ctl_clk);
        #1 check(stop_busy == 1'b1, "R11", "busy at acceptance", stop_busy, 1);
        #40 for (int j = 0; j < N_CPU; j++) check_pair_parked(j, "R4");
        #8  for (int j = N_CPU; j < N_CPU + N_SRC; j++) check_pair_parked(j, "R4");
        #8  for (int j = N_CPU + N_SRC; j < N_DIFF; j++) check_pair_parked(j, "R4");
        #24 check(se_out[1] == 1'b0, "R3", "se 1 low in bound", se_out[1], 0);
        #40 check(se_out[0] == 1'b0, "R3", "se 0 low in bound", se_out[0], 0);
        #48 check(se_out[2] == 1'b0, "R3", "se 2 low in bound", se_out[2], 0);
        check(stop_busy == 1'b0, "R11", "busy after all parked", stop_busy, 0);
    endtask

    initial begin
        rst_n = 1'b0; pwr_pin = 1'b1; pll_locked = 1'b1;
        se_en = '1; dif_en = '1;
        float_cpu = 1'b0; float_src = 1'b1; float_dot = 1'b0;
        clear_counts();
        // Reset state: parked per float bits (R5, R6, R7), no status.
        #150;
        for (int i = 0; i < N_SE; i++) check(se_out[i] == 1'b0, "R3", "se low in reset", se_out[i], 0);
        for (int j = 0; j < N_DIFF; j++) check_pair_parked(j, "R7");
        check(stop_busy == 1'b0, "R11", "busy in reset", stop_busy, 0);
        @(negedge ctl_clk) rst_n = 1'b1;

        // R1: pin high after reset means power not good: stay parked.
        #100 check_all_parked("R1");

        // R1, R9: pin low gives power-good, outputs start.
        @(negedge ctl_clk) pwr_pin = 1'b0;
        #200 check_running("R9", '1, '1);

        // R2: pin high for a single sample is ignored.
        busy_seen = 1'b0;
        @(negedge ctl_clk) pwr_pin = 1'b1;
        @(negedge ctl_clk) pwr_pin = 1'b0;
        check_running("R2", '1, '1);
        check(!busy_seen, "R2", "single-sample pulse accepted", busy_seen, 0);

        // R2, R3, R4, R5, R6, R11: power-down with cpu/dot driven, src floating.
        power_down_staggered();
        check_all_parked("R5");

        // R8: release without lock keeps everything parked.
        @(negedge ctl_clk) pll_locked = 1'b0;
        pwr_pin = 1'b0;
        #150 check_all_parked("R8");
        @(negedge ctl_clk) pll_locked = 1'b1;
        // R9: all outputs up within 3 ctl periods plus 4 own periods.
        check_running("R9", '1, '1);

        // R6, R7: swapped float bits give swapped parked states.
        float_cpu = 1'b1; float_src = 1'b0; float_dot = 1'b1;
        power_down_staggered();
        check_all_parked("R6");
        @(negedge ctl_clk) pwr_pin = 1'b0;
        #200 check_running("R9", '1, '1);

        // R10: clearing enables parks those outputs only, without power-down.
        float_src = 1'b0;
        busy_seen = 1'b0;
        @(negedge ctl_clk) begin se_en[1] = 1'b0; dif_en[2] = 1'b0; end
        #100;
        check(se_out[1] == 1'b0, "R10", "disabled se low", se_out[1], 0);
        check(!dif_t_oe[2] && !dif_c_oe[2], "R10", "disabled pair floats", {dif_t_oe[2], dif_c_oe[2]}, 0);
        clear_counts();
        #150;
        check(se_edges[1] == 0 && dif_edges[2] == 0, "R10", "disabled edges",
              se_edges[1] + dif_edges[2], 0);
        check_running("R10", 3'b101, 5'b11011);
        check(!busy_seen, "R11", "busy without power-down", busy_seen, 0);

        // R10: a disabled output stays parked across a power-down cycle.
        @(negedge ctl_clk) pwr_pin = 1'b1;
        #250 @(negedge ctl_clk) pwr_pin = 1'b0;
        #200;
        clear_counts();
        #150;
        check(se_edges[1] == 0 && dif_edges[2] == 0, "R10", "disabled after cycle",
              se_edges[1] + dif_edges[2], 0);
        check_running("R10", 3'b101, 5'b11011);

        // R10: setting the enables again restarts the outputs.
        @(negedge ctl_clk) begin se_en[1] = 1'b1; dif_en[2] = 1'b1; end
        #200 check_running("R10", '1, '1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(WATCHDOG * CLK_PERIOD);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule